// File: doc/BRIEF.md
# Receive Phase Compensation FIFO

This block carries parallel receive words from the recovered receiver clock domain into the fabric clock domain. It is a four-entry dual-clock FIFO. The word width is a parameter, so it can be 8, 10, 16 or 20 bits. The write and read pointers cross between the domains in Gray code, through two-flop synchronizers. The write side has a full flag and the read side has an empty flag. A write while full or a read while empty sets a sticky error flag in the domain where the fault happened.

A build-time mode parameter picks the implementation. In the default asynchronous mode the words go through the four-entry store. The registered mode assumes that both clocks are the same net. In that mode the store is bypassed and each written word passes through a single read-side register, so the latency is fixed at one cycle.

A second build-time option mirrors the bit order inside every complete byte of the read data. Any bits above the last complete byte pass through unchanged.

Top module: `rx_phase_fifo`

## Requirements
- R1: After both resets, wr_full, wr_err, rd_valid and rd_err are 0, and rd_empty is 1.
- R2: In asynchronous mode, words are presented on rd_data, with rd_valid high, in the order they were accepted. No word is lost or repeated.
- R3: In asynchronous mode, exactly four words are accepted with no reads. After the fourth accepted write, wr_full reads 1.
- R4: When every written word has been read, rd_empty returns to 1. A read request while empty produces no rd_valid pulse.
- R5: A write request while wr_full is 1 stores nothing and sets wr_err. wr_err then stays 1 until reset.
- R6: A read request while rd_empty is 1 sets rd_err. rd_err then stays 1 until reset, and a reset clears it.
- R7: In asynchronous mode, suppose a word is written into an empty FIFO and the reader requests whenever rd_empty is 0. The word then appears with rd_valid within five read clock cycles of its write edge.
- R8: In registered mode, the word presented with wr_en at a clock edge appears on rd_data, with rd_valid high, right after that same edge. A cycle without wr_en gives rd_valid 0 on the following cycle.
- R9: With mirroring enabled, bit 8b+k of the output equals bit 8b+7-k of the stored word for every complete byte b, and bits above the last complete byte are unchanged. For example, 16'hBCAD comes out as 16'h3DB5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered receive clock (write side) |
| wr_rst | input | 1 | Synchronous active-high reset, write side |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Word to store |
| wr_full | output | 1 | All four entries are occupied |
| wr_err | output | 1 | Sticky overflow flag |
| rd_clk | input | 1 | Fabric clock (read side) |
| rd_rst | input | 1 | Synchronous active-high reset, read side |
| rd_en | input | 1 | Read request |
| rd_data | output | WIDTH | Read word, optionally byte-mirrored |
| rd_valid | output | 1 | rd_data holds a fresh word this cycle |
| rd_empty | output | 1 | No word is available to read |
| rd_err | output | 1 | Sticky underflow flag |

## Verification
The assertions assume that each reset is held for several edges of its own clock. This fills the pointer and synchronizer history with reset values before any property looks back. They also assume that both resets are applied together, because resetting only one side would leave the pointers misaligned. The stimulus drives every input on the falling edge of its own clock. It releases both resets in the same stretch of time and, in the whole-block reset test, pulses them together. It makes ordinary requests only after reading the flags, so overflow and underflow happen only in the dedicated tests.

// File: rtl/rpc_pkg.sv
`timescale 1ns/1ps
package rpc_pkg;
  typedef enum logic {
    RPC_MODE_ASYNC = 1'b0,
    RPC_MODE_REG   = 1'b1
  } rpc_mode_e;
endpackage

// File: rtl/rpc_sync.sv
`timescale 1ns/1ps
module rpc_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/rpc_wr_ctl.sv
`timescale 1ns/1ps
module rpc_wr_ctl #(
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [AW:0]   rgray_s,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          we,
  output logic          full,
  output logic          err
);
  logic [AW:0] wbin;

  assign waddr = wbin[AW-1:0];
  assign full  = (wgray == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
  assign we    = en && !full;

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin  <= '0;
      wgray <= '0;
      err   <= 1'b0;
    end else begin
      if (we) begin
        wbin  <= wbin + 1'b1;
        wgray <= (wbin + 1'b1) ^ ((wbin + 1'b1) >> 1);
      end
      if (en && full) err <= 1'b1;
    end
  end

  a_r3_full_holds_pointer: assert property (@(posedge clk) disable iff (rst)
    full |=> (wbin == $past(wbin)));
  a_r5_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
  a_r2_wgray_single_step: assert property (@(posedge clk) disable iff (rst)
    $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/rpc_rd_ctl.sv
`timescale 1ns/1ps
module rpc_rd_ctl #(
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [AW:0]   wgray_s,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic          fire,
  output logic          empty,
  output logic          err
);
  logic [AW:0] rbin;

  assign raddr = rbin[AW-1:0];
  assign empty = (rgray == wgray_s);
  assign fire  = en && !empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin  <= '0;
      rgray <= '0;
      err   <= 1'b0;
    end else begin
      if (fire) begin
        rbin  <= rbin + 1'b1;
        rgray <= (rbin + 1'b1) ^ ((rbin + 1'b1) >> 1);
      end
      if (en && empty) err <= 1'b1;
    end
  end

  a_r4_empty_holds_pointer: assert property (@(posedge clk) disable iff (rst)
    empty |=> (rbin == $past(rbin)));
  a_r6_underflow_sticky: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
  a_r2_rgray_single_step: assert property (@(posedge clk) disable iff (rst)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/rpc_byte_mirror.sv
`timescale 1ns/1ps
module rpc_byte_mirror #(
  parameter int W    = 16,
  parameter bit FLIP = 1'b0
) (
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int FULL_BYTES = W / 8;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (FLIP && (i / 8) < FULL_BYTES) begin : g_swap
      assign q[(i / 8) * 8 + 7 - (i % 8)] = d[i];
    end else begin : g_keep
      assign q[i] = d[i];
    end
  end
endmodule

// File: rtl/rx_phase_fifo.sv
`timescale 1ns/1ps
module rx_phase_fifo
  import rpc_pkg::*;
#(
  parameter int        WIDTH = 16,
  parameter int        DEPTH = 4,
  parameter rpc_mode_e MODE  = RPC_MODE_ASYNC,
  parameter bit        FLIP  = 1'b0
) (
  input  logic             wr_clk,
  input  logic             wr_rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic             wr_full,
  output logic             wr_err,
  input  logic             rd_clk,
  input  logic             rd_rst,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  output logic             rd_empty,
  output logic             rd_err
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] q_r;

  if (MODE == RPC_MODE_ASYNC) begin : g_async
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    waddr, raddr;
    logic [AW:0]      wgray, rgray, wgray_s, rgray_s;
    logic             we, fire, valid_r;

    rpc_wr_ctl #(.AW(AW)) u_wr (
      .clk(wr_clk), .rst(wr_rst), .en(wr_en), .rgray_s(rgray_s),
      .waddr(waddr), .wgray(wgray), .we(we), .full(wr_full), .err(wr_err));

    rpc_rd_ctl #(.AW(AW)) u_rd (
      .clk(rd_clk), .rst(rd_rst), .en(rd_en), .wgray_s(wgray_s),
      .raddr(raddr), .rgray(rgray), .fire(fire), .empty(rd_empty), .err(rd_err));

    rpc_sync #(.W(AW + 1)) u_w2r (.clk(rd_clk), .rst(rd_rst), .d(wgray), .q(wgray_s));
    rpc_sync #(.W(AW + 1)) u_r2w (.clk(wr_clk), .rst(wr_rst), .d(rgray), .q(rgray_s));

    always_ff @(posedge wr_clk) begin
      if (we) mem[waddr] <= wr_data;
    end

    always_ff @(posedge rd_clk) begin
      if (fire) q_r <= mem[raddr];
    end

    always_ff @(posedge rd_clk) begin
      if (rd_rst) valid_r <= 1'b0;
      else        valid_r <= fire;
    end
    assign rd_valid = valid_r;

    a_r4_valid_after_nonempty: assert property (@(posedge rd_clk) disable iff (rd_rst)
      rd_valid |-> $past(rd_en && !rd_empty));
  end else begin : g_reg
    logic valid_r;

    always_ff @(posedge rd_clk) begin
      q_r <= wr_data;
    end

    always_ff @(posedge rd_clk) begin
      if (rd_rst) valid_r <= 1'b0;
      else        valid_r <= wr_en;
    end

    assign rd_valid = valid_r;
    assign wr_full  = 1'b0;
    assign wr_err   = 1'b0;
    assign rd_empty = 1'b1;
    assign rd_err   = 1'b0;
  end

  rpc_byte_mirror #(.W(WIDTH), .FLIP(FLIP)) u_mirror (.d(q_r), .q(rd_data));
endmodule

// File: tb/test_rx_phase_fifo.sv
`timescale 1ns/1ps
module test_rx_phase_fifo;
  import rpc_pkg::*;

  logic wclk = 1'b0, rclk = 1'b0;
  logic wrst = 1'b1, rrst = 1'b1;
  always #2    wclk = ~wclk;
  always #2.65 rclk = ~rclk;

  // asynchronous instance, 16 bits, no mirroring
  logic        u_wen = 1'b0, u_ren = 1'b0;
  logic [15:0] u_wd = '0, u_rd;
  logic        u_wfull, u_werr, u_rvalid, u_rempty, u_rerr;

  rx_phase_fifo #(.WIDTH(16), .DEPTH(4), .MODE(RPC_MODE_ASYNC), .FLIP(1'b0)) i_rx_phase_fifo (
    .wr_clk(wclk), .wr_rst(wrst), .wr_en(u_wen), .wr_data(u_wd), .wr_full(u_wfull), .wr_err(u_werr),
    .rd_clk(rclk), .rd_rst(rrst), .rd_en(u_ren), .rd_data(u_rd), .rd_valid(u_rvalid),
    .rd_empty(u_rempty), .rd_err(u_rerr));

  // registered instances on one clock, mirroring on
  logic        g_wen = 1'b0;
  logic [15:0] g_wd = '0, g_rd;
  logic        g_rvalid, g_f, g_e, g_re, g_empty;
  logic [9:0]  h_wd = '0, h_rd;
  logic        h_rvalid, h_f, h_e, h_re, h_empty;

  rx_phase_fifo #(.WIDTH(16), .DEPTH(4), .MODE(RPC_MODE_REG), .FLIP(1'b1)) i_rx_phase_fifo_reg16 (
    .wr_clk(wclk), .wr_rst(wrst), .wr_en(g_wen), .wr_data(g_wd), .wr_full(g_f), .wr_err(g_e),
    .rd_clk(wclk), .rd_rst(wrst), .rd_en(1'b0), .rd_data(g_rd), .rd_valid(g_rvalid),
    .rd_empty(g_empty), .rd_err(g_re));

  rx_phase_fifo #(.WIDTH(10), .DEPTH(4), .MODE(RPC_MODE_REG), .FLIP(1'b1)) i_rx_phase_fifo_reg10 (
    .wr_clk(wclk), .wr_rst(wrst), .wr_en(g_wen), .wr_data(h_wd), .wr_full(h_f), .wr_err(h_e),
    .rd_clk(wclk), .rd_rst(wrst), .rd_en(1'b0), .rd_data(h_rd), .rd_valid(h_rvalid),
    .rd_empty(h_empty), .rd_err(h_re));

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;
  logic [15:0] exp_q[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  function automatic logic [31:0] mirror(input logic [31:0] d, input int w);
    logic [31:0] r = d;
    for (int b = 0; b < w / 8; b++)
      for (int k = 0; k < 8; k++) r[8 * b + k] = d[8 * b + 7 - k];
    return r;
  endfunction

  task automatic wr_word(input logic [15:0] d);
    @(negedge wclk); u_wen = 1'b1; u_wd = d;
    @(negedge wclk); u_wen = 1'b0;
  endtask

  task automatic drain(input int n, input string req);
    int got = 0, issued = 0, guard = 0;
    while (got < n && guard < 200) begin
      @(negedge rclk);
      guard++;
      if (u_rvalid) begin
        chk(req, u_rd, exp_q.pop_front());
        got++;
      end
      if (issued < n && !u_rempty) begin u_ren = 1'b1; issued++; end
      else u_ren = 1'b0;
    end
    u_ren = 1'b0;
    if (got < n) chk({req, " drain timeout"}, got, n);
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    wrap_up();
  end

  initial begin
    repeat (6) @(negedge wclk);
    wrst = 1'b0; rrst = 1'b0;
    repeat (3) @(negedge rclk);
    @(negedge wclk);
    // R1 reset state
    chk("R1 wr_full", u_wfull, 0);
    chk("R1 wr_err", u_werr, 0);
    chk("R1 rd_empty", u_rempty, 1);
    chk("R1 rd_valid", u_rvalid, 0);
    chk("R1 rd_err", u_rerr, 0);
    chk("R1 reg rd_valid", g_rvalid, 0);

    // R2 / R4: fill levels 1..4 then drain
    for (int n = 1; n <= 4; n++) begin
      for (int k = 0; k < n; k++) begin
        logic [15:0] v = 16'(n * 4096 + k * 257 + 3);
        exp_q.push_back(v);
        wr_word(v);
      end
      repeat (8) @(negedge rclk);
      drain(n, "R2 order");
      repeat (3) @(negedge rclk);
      chk("R4 empty after drain", u_rempty, 1);
      chk("R4 no spurious valid", u_rvalid, 0);
    end

    // R3 capacity
    for (int k = 0; k < 4; k++) begin
      exp_q.push_back(16'hA000 + 16'(k));
      wr_word(16'hA000 + 16'(k));
    end
    chk("R3 full after four", u_wfull, 1);
    chk("R3 no error yet", u_werr, 0);

    // R5 overflow
    wr_word(16'hDEAD);
    chk("R5 wr_err set", u_werr, 1);
    repeat (8) @(negedge rclk);
    drain(4, "R5 dropped word absent");
    repeat (4) @(negedge rclk);
    chk("R5 empty after four", u_rempty, 1);
    repeat (6) @(negedge wclk);
    chk("R5 full clears", u_wfull, 0);
    chk("R5 wr_err sticky", u_werr, 1);

    // R7 latency
    exp_q.push_back(16'h1234);
    wr_word(16'h1234);
    begin
      int c = 0;
      while (c < 10) begin
        @(negedge rclk);
        c++;
        if (u_rvalid) break;
        u_ren = !u_rempty;
      end
      u_ren = 1'b0;
      chk("R7 valid seen", u_rvalid, 1);
      chk("R7 data", u_rd, exp_q.pop_front());
      chk("R7 cycles within five", (c <= 5), 1);
    end

    // R2 streaming with concurrent sides
    fork
      begin
        int k = 0;
        while (k < 40) begin
          @(negedge wclk);
          if (!u_wfull) begin
            u_wen = 1'b1; u_wd = 16'(k * 1103 + 77);
            exp_q.push_back(u_wd); k++;
          end else u_wen = 1'b0;
        end
        @(negedge wclk); u_wen = 1'b0;
      end
      drain(40, "R2 stream");
    join
    chk("R2 rd_err untouched", u_rerr, 0);

    // R6 underflow
    repeat (4) @(negedge rclk);
    u_ren = 1'b1;
    @(negedge rclk); u_ren = 1'b0;
    chk("R6 rd_err set", u_rerr, 1);
    chk("R6 no valid on empty read", u_rvalid, 0);
    repeat (5) @(negedge rclk);
    chk("R6 rd_err sticky", u_rerr, 1);
    @(negedge wclk); wrst = 1'b1; rrst = 1'b1;
    repeat (6) @(negedge wclk);
    wrst = 1'b0; rrst = 1'b0;
    repeat (3) @(negedge rclk);
    @(negedge wclk);
    chk("R6 reset clears rd_err", u_rerr, 0);
    chk("R5 reset clears wr_err", u_werr, 0);

    // R8 / R9 registered mode, exhaustive over 10-bit values
    for (int v = 0; v < 1024; v++) begin
      @(negedge wclk);
      g_wen = 1'b1;
      g_wd  = {v[7:0], v[9:2]} ^ 16'h5A3C;
      h_wd  = 10'(v);
      @(negedge wclk);
      chk("R8 reg valid", g_rvalid, 1);
      chk("R9 mirror 16", g_rd, mirror(32'(g_wd), 16));
      chk("R9 mirror 10", h_rd, mirror(32'(h_wd), 10));
    end
    @(negedge wclk); g_wen = 1'b1; g_wd = 16'hBCAD;
    @(negedge wclk); g_wen = 1'b0;
    chk("R9 BCAD example", g_rd, 16'h3DB5);
    chk("R8 one-cycle valid", g_rvalid, 1);
    @(negedge wclk);
    chk("R8 idle cycle no valid", g_rvalid, 0);
    chk("R8 idle cycle no valid 10", h_rvalid, 0);

    wrap_up();
  end
endmodule